// File: doc/BRIEF.md
# Execution-Control Capability Checker

This block stores the capability values that say which settings of two 32-bit execution-control words are permitted. The first word holds external-event controls and the second holds primary processor controls. Before a guest is entered, software or a sequencer presents both candidate words with a start strobe. One cycle later the block returns a pass bit and, for each word, a mask of the bits that break the rules.

Each 64-bit capability value has two halves. The low half lists the bits that must be 1, and the high half lists the bits that may be 1. Every capability value is fixed by a parameter at elaboration. A flag at bit 55 of the basic capability value selects one of two sets of registers. With the flag clear, the legacy set applies. In that set, a fixed group of default-one bits always reads back as must-be-1, whatever its parameter says. With the flag set, an unrestricted set applies, with no such exceptions. A registered read port, addressed by a 12-bit index, returns any capability value.

Top module: `ctlcap_checker`

## Requirements
- R1: When control bit X is 0 and bit X of the active capability's low (must-be-1) half is 1, bit X of that word's failure mask is 1 in the result.
- R2: When control bit X is 1 and bit 32+X of the active capability's high (may-be-1) half is 0, bit X of that word's failure mask is 1 in the result.
- R3: `res_valid` is 1 for exactly the one cycle after each cycle with `chk_start` high. `res_pass` is 1 exactly when both failure masks are all-zero.
- R4: In the legacy external-event capability (index 0x481), low-half bits 1, 2 and 4 read back as 1 whatever the parameter holds. All other bits come from the parameter.
- R5: In the legacy processor capability (index 0x482), low-half bits 1, 4, 5, 6, 8, 13, 14, 15, 16 and 26 read back as 1. All other bits come from the parameter.
- R6: With bit 55 of the basic value at 0, checks use the legacy values as read back. Any default-one control left at 0 is therefore flagged.
- R7: With bit 55 at 1, checks use the unrestricted values (0x48D external-event, 0x48E processor) exactly as given, with no forced bits.
- R8: A read with `rd_en` high returns, in the next cycle, `rd_valid`=1 with the value at the index: 0x480 basic, 0x481, 0x482, 0x48D, 0x48E. `rd_err` is 0 on such a read, except as stated in R9.
- R9: When bit 55 is 0, a read of 0x48D or 0x48E returns `rd_err`=1 and zero data.
- R10: A read at any other index returns `rd_err`=1 and zero data. No read changes `res_pass` or either failure mask.
- R11: After reset, `res_valid`, `res_pass`, both masks, `rd_valid`, `rd_err` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_start | input | 1 | Starts a check of the two candidate words |
| chk_pin_ctl | input | 32 | Candidate external-event control word |
| chk_proc_ctl | input | 32 | Candidate primary processor control word |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_pass | output | 1 | Both words are legal |
| res_pin_fail | output | 32 | Offending bits of the external-event word |
| res_proc_fail | output | 32 | Offending bits of the processor word |
| rd_en | input | 1 | Read request |
| rd_idx | input | 12 | Capability index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Capability value |
| rd_err | output | 1 | Index unknown or not supported in this mode |

## Verification
The bench builds two instances side by side, one in legacy mode and one in unrestricted mode. It drives walking-one and walking-zero words through every bit position, plus a long pseudo-random sequence. This lets it tell apart a design that forgets the forced default-one bits, applies them in the wrong mode, or swaps the must-be-1 and may-be-1 halves; any of these gives wrong masks at specific positions. It reads every legal index, the unrestricted indices in legacy mode, and indices next to the legal ones. A decoder that aliases nearby indices, leaks data on an error, or disturbs the held check result would show up there.

// File: rtl/ctlcap_pkg.sv
package ctlcap_pkg;

    localparam int CTL_W = 32;
    localparam int CAP_W = 2 * CTL_W;
    localparam int IDX_W = 12;
    localparam int MODE_BIT = 55;

    localparam logic [IDX_W-1:0] IDX_BASIC     = 12'h480;
    localparam logic [IDX_W-1:0] IDX_PIN_LEG   = 12'h481;
    localparam logic [IDX_W-1:0] IDX_PROC_LEG  = 12'h482;
    localparam logic [IDX_W-1:0] IDX_PIN_TRUE  = 12'h48D;
    localparam logic [IDX_W-1:0] IDX_PROC_TRUE = 12'h48E;

    // bits forced to must-be-1 in the legacy values
    localparam logic [CTL_W-1:0] PIN_FORCED  = 32'h0000_0016;
    localparam logic [CTL_W-1:0] PROC_FORCED = 32'h0401_E172;

    typedef struct packed {
        logic [CTL_W-1:0] may1;
        logic [CTL_W-1:0] must1;
    } cap_t;

    typedef enum logic [2:0] {
        SEL_BASIC,
        SEL_PIN_LEG,
        SEL_PROC_LEG,
        SEL_PIN_TRUE,
        SEL_PROC_TRUE,
        SEL_NONE
    } rd_sel_e;

    function automatic rd_sel_e decode_idx(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_BASIC:     return SEL_BASIC;
            IDX_PIN_LEG:   return SEL_PIN_LEG;
            IDX_PROC_LEG:  return SEL_PROC_LEG;
            IDX_PIN_TRUE:  return SEL_PIN_TRUE;
            IDX_PROC_TRUE: return SEL_PROC_TRUE;
            default:       return SEL_NONE;
        endcase
    endfunction

    function automatic cap_t force_low(input logic [CAP_W-1:0] raw,
                                       input logic [CTL_W-1:0] forced);
        cap_t c;
        c.may1  = raw[CAP_W-1:CTL_W];
        c.must1 = raw[CTL_W-1:0] | forced;
        return c;
    endfunction

endpackage

// File: rtl/ctlcap_capstore.sv
module ctlcap_capstore
    import ctlcap_pkg::*;
#(
    parameter logic [CAP_W-1:0] BASIC_CAP     = 64'h0080_0000_0000_0000,
    parameter logic [CAP_W-1:0] PIN_LEG_CAP   = 64'h0000_007F_0000_0016,
    parameter logic [CAP_W-1:0] PROC_LEG_CAP  = 64'hFFFF_FFFF_0401_E172,
    parameter logic [CAP_W-1:0] PIN_TRUE_CAP  = 64'h0000_007F_0000_0000,
    parameter logic [CAP_W-1:0] PROC_TRUE_CAP = 64'hFFFF_FFFF_0000_0000
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CAP_W-1:0] rd_value,
    output logic             rd_bad,
    output cap_t             pin_cap,
    output cap_t             proc_cap
);
    localparam logic TRUE_MODE = BASIC_CAP[MODE_BIT];

    cap_t pin_leg, proc_leg, pin_true, proc_true;

    assign pin_leg   = force_low(PIN_LEG_CAP, PIN_FORCED);
    assign proc_leg  = force_low(PROC_LEG_CAP, PROC_FORCED);
    assign pin_true  = cap_t'(PIN_TRUE_CAP);
    assign proc_true = cap_t'(PROC_TRUE_CAP);

    generate
        if (TRUE_MODE) begin : g_true
            assign pin_cap  = pin_true;
            assign proc_cap = proc_true;
        end else begin : g_legacy
            assign pin_cap  = pin_leg;
            assign proc_cap = proc_leg;
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        rd_bad   = 1'b0;
        unique case (decode_idx(idx))
            SEL_BASIC:     rd_value = BASIC_CAP;
            SEL_PIN_LEG:   rd_value = pin_leg;
            SEL_PROC_LEG:  rd_value = proc_leg;
            SEL_PIN_TRUE: begin
                if (TRUE_MODE) rd_value = pin_true;
                else           rd_bad   = 1'b1;
            end
            SEL_PROC_TRUE: begin
                if (TRUE_MODE) rd_value = proc_true;
                else           rd_bad   = 1'b1;
            end
            default:       rd_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/ctlcap_word_check.sv
module ctlcap_word_check
    import ctlcap_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  cap_t             cap,
    output logic [CTL_W-1:0] bad
);
    generate
        for (genvar b = 0; b < CTL_W; b++) begin : g_bit
            logic low_miss;
            logic high_miss;
            assign low_miss  = ~ctl[b] & cap.must1[b];
            assign high_miss = ctl[b] & ~cap.may1[b];
            assign bad[b]    = low_miss | high_miss;
        end
    endgenerate
endmodule

// File: rtl/ctlcap_checker.sv
module ctlcap_checker
    import ctlcap_pkg::*;
#(
    parameter logic [CAP_W-1:0] BASIC_CAP     = 64'h0080_0000_0000_0000,
    parameter logic [CAP_W-1:0] PIN_LEG_CAP   = 64'h0000_007F_0000_0016,
    parameter logic [CAP_W-1:0] PROC_LEG_CAP  = 64'hFFFF_FFFF_0401_E172,
    parameter logic [CAP_W-1:0] PIN_TRUE_CAP  = 64'h0000_007F_0000_0000,
    parameter logic [CAP_W-1:0] PROC_TRUE_CAP = 64'hFFFF_FFFF_0000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_start,
    input  logic [31:0]      chk_pin_ctl,
    input  logic [31:0]      chk_proc_ctl,
    output logic             res_valid,
    output logic             res_pass,
    output logic [31:0]      res_pin_fail,
    output logic [31:0]      res_proc_fail,
    input  logic             rd_en,
    input  logic [11:0]      rd_idx,
    output logic             rd_valid,
    output logic [63:0]      rd_data,
    output logic             rd_err
);
    cap_t             pin_cap, proc_cap;
    logic [CAP_W-1:0] rd_value;
    logic             rd_bad;
    logic [CTL_W-1:0] pin_bad, proc_bad;

    ctlcap_capstore #(
        .BASIC_CAP    (BASIC_CAP),
        .PIN_LEG_CAP  (PIN_LEG_CAP),
        .PROC_LEG_CAP (PROC_LEG_CAP),
        .PIN_TRUE_CAP (PIN_TRUE_CAP),
        .PROC_TRUE_CAP(PROC_TRUE_CAP)
    ) u_store (
        .idx     (rd_idx),
        .rd_value(rd_value),
        .rd_bad  (rd_bad),
        .pin_cap (pin_cap),
        .proc_cap(proc_cap)
    );

    ctlcap_word_check u_pin_chk (
        .ctl(chk_pin_ctl),
        .cap(pin_cap),
        .bad(pin_bad)
    );

    ctlcap_word_check u_proc_chk (
        .ctl(chk_proc_ctl),
        .cap(proc_cap),
        .bad(proc_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_pass      <= 1'b0;
            res_pin_fail  <= '0;
            res_proc_fail <= '0;
        end else begin
            res_valid <= chk_start;
            if (chk_start) begin
                res_pass      <= ~(|pin_bad) & ~(|proc_bad);
                res_pin_fail  <= pin_bad;
                res_proc_fail <= proc_bad;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_value;
                rd_err  <= rd_bad;
            end
        end
    end

endmodule

// File: rtl/ctlcap_checker_sva.sv
module ctlcap_checker_sva (
    input logic        clk,
    input logic        rst,
    input logic        chk_start,
    input logic        res_valid,
    input logic        res_pass,
    input logic [31:0] res_pin_fail,
    input logic [31:0] res_proc_fail,
    input logic        rd_en,
    input logic        rd_valid,
    input logic [63:0] rd_data,
    input logic        rd_err
);
    a_r3_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        chk_start |=> res_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !chk_start |=> !res_valid);

    a_r3_pass_means_clean: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_pass == ((res_pin_fail == '0) && (res_proc_fail == '0))));

    a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
        !chk_start |=> ($stable(res_pass) && $stable(res_pin_fail) && $stable(res_proc_fail)));

    a_r8_read_answers: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r9_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_err) |-> (rd_data == '0));
endmodule

bind ctlcap_checker ctlcap_checker_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .chk_start    (chk_start),
    .res_valid    (res_valid),
    .res_pass     (res_pass),
    .res_pin_fail (res_pin_fail),
    .res_proc_fail(res_proc_fail),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_err       (rd_err)
);

// File: tb/ctlcap_checker_bench.sv
`timescale 1ns/1ps
module ctlcap_checker_bench;

    localparam logic [63:0] B_LEG   = 64'h0000_0000_0000_1234;
    localparam logic [63:0] B_TRUE  = 64'h0080_0000_0000_1234;
    localparam logic [63:0] PIN_L   = {32'h0000_00FF, 32'h0000_0001};
    localparam logic [63:0] PROC_L  = {32'h7FFF_FFFE, 32'h0000_0200};
    localparam logic [63:0] PIN_T   = {32'h0000_007F, 32'h0000_0001};
    localparam logic [63:0] PROC_T  = {32'hFFFF_FF00, 32'h8000_0000};
    localparam logic [31:0] F_PIN   = 32'h0000_0016;
    localparam logic [31:0] F_PROC  = 32'h0401_E172;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        chk_start = 1'b0;
    logic [31:0] pin_w = '0, proc_w = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_idx = '0;

    logic        lv, lp, tv, tp, lrv, lre, trv, tre;
    logic [31:0] lpf, lqf, tpf, tqf;
    logic [63:0] lrd, trd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ctlcap_checker #(.BASIC_CAP(B_LEG), .PIN_LEG_CAP(PIN_L), .PROC_LEG_CAP(PROC_L),
                     .PIN_TRUE_CAP(PIN_T), .PROC_TRUE_CAP(PROC_T)) u_ctlcap_checker (
        .clk(clk), .rst(rst), .chk_start(chk_start), .chk_pin_ctl(pin_w),
        .chk_proc_ctl(proc_w), .res_valid(lv), .res_pass(lp), .res_pin_fail(lpf),
        .res_proc_fail(lqf), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(lrv),
        .rd_data(lrd), .rd_err(lre));

    ctlcap_checker #(.BASIC_CAP(B_TRUE), .PIN_LEG_CAP(PIN_L), .PROC_LEG_CAP(PROC_L),
                     .PIN_TRUE_CAP(PIN_T), .PROC_TRUE_CAP(PROC_T)) u_ctlcap_checker_true (
        .clk(clk), .rst(rst), .chk_start(chk_start), .chk_pin_ctl(pin_w),
        .chk_proc_ctl(proc_w), .res_valid(tv), .res_pass(tp), .res_pin_fail(tpf),
        .res_proc_fail(tqf), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(trv),
        .rd_data(trd), .rd_err(tre));

    task automatic expect64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mask(input logic [31:0] ctl,
                                             input logic [31:0] must, input logic [31:0] may);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) begin
            if (ctl[i] == 1'b0 && must[i]) m[i] = 1'b1;
            if (ctl[i] == 1'b1 && !may[i]) m[i] = 1'b1;
        end
        return m;
    endfunction

    // legacy instance: forced bits added to must-be-1 (R4, R5, R6)
    // unrestricted instance: values as given (R7)
    task automatic run_check(input logic [31:0] p, input logic [31:0] q, input string tag);
        logic [31:0] elp, elq, etp, etq;
        @(negedge clk);
        chk_start = 1'b1; pin_w = p; proc_w = q;
        @(negedge clk);
        chk_start = 1'b0;
        elp = ref_mask(p, PIN_L[31:0] | F_PIN, PIN_L[63:32]);
        elq = ref_mask(q, PROC_L[31:0] | F_PROC, PROC_L[63:32]);
        etp = ref_mask(p, PIN_T[31:0], PIN_T[63:32]);
        etq = ref_mask(q, PROC_T[31:0], PROC_T[63:32]);
        expect64({tag, " R1/R2/R6 legacy pin mask"}, {32'h0, lpf}, {32'h0, elp});
        expect64({tag, " R1/R2/R6 legacy proc mask"}, {32'h0, lqf}, {32'h0, elq});
        expect64({tag, " R7 true pin mask"}, {32'h0, tpf}, {32'h0, etp});
        expect64({tag, " R7 true proc mask"}, {32'h0, tqf}, {32'h0, etq});
        expect64({tag, " R3 valid/pass"}, {60'h0, lv, lp, tv, tp},
                 {60'h0, 1'b1, (elp == 0 && elq == 0), 1'b1, (etp == 0 && etq == 0)});
    endtask

    task automatic run_read(input logic [11:0] idx, input logic [63:0] ld, input logic le,
                            input logic [63:0] td, input logic te, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        expect64({tag, " legacy data"}, lrd, ld);
        expect64({tag, " true data"}, trd, td);
        expect64({tag, " valid/err"}, {60'h0, lrv, lre, trv, tre}, {60'h0, 1'b1, le, 1'b1, te});
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] hp, hq;
        logic [63:0] pin_l_rd, proc_l_rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        expect64("R11 legacy result", {lpf, lqf}, 64'h0);
        expect64("R11 true result", {tpf, tqf}, 64'h0);
        expect64("R11 flags", {56'h0, lv, lp, tv, tp, lrv, lre, trv, tre}, 64'h0);
        expect64("R11 read data", lrd | trd, 64'h0);

        run_check(32'h0, 32'h0, "zeros");
        run_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, "ones");
        run_check(PIN_L[31:0] | F_PIN, PROC_L[31:0] | F_PROC, "legacy minimum");
        run_check(PIN_T[31:0], PROC_T[31:0], "true minimum");
        // R3: valid drops after one cycle
        @(negedge clk);
        expect64("R3 valid single pulse", {62'h0, lv, tv}, 64'h0);

        for (int b = 0; b < 32; b++) begin
            run_check(32'h1 << b, 32'h1 << b, "walk1");
            run_check(~(32'h1 << b), ~(32'h1 << b), "walk0");
        end

        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            hp = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            hq = lfsr;
            run_check(hp | (n[0] ? F_PIN : 32'h0), hq | (n[1] ? F_PROC : 32'h0), "random");
        end

        // reads: R4, R5, R8, R9
        pin_l_rd  = {PIN_L[63:32], PIN_L[31:0] | F_PIN};
        proc_l_rd = {PROC_L[63:32], PROC_L[31:0] | F_PROC};
        run_read(12'h480, B_LEG, 1'b0, B_TRUE, 1'b0, "R8 basic");
        run_read(12'h481, pin_l_rd, 1'b0, pin_l_rd, 1'b0, "R4 legacy pin");
        run_read(12'h482, proc_l_rd, 1'b0, proc_l_rd, 1'b0, "R5 legacy proc");
        run_read(12'h48D, 64'h0, 1'b1, PIN_T, 1'b0, "R9 true pin");
        run_read(12'h48E, 64'h0, 1'b1, PROC_T, 1'b0, "R9 true proc");

        // R10: illegal indices, result held across reads
        run_check(32'h0000_0100, 32'h0000_0001, "before reads");
        hp = lpf; hq = lqf;
        run_read(12'h483, 64'h0, 1'b1, 64'h0, 1'b1, "R10 idx 483");
        run_read(12'h48C, 64'h0, 1'b1, 64'h0, 1'b1, "R10 idx 48C");
        run_read(12'h48F, 64'h0, 1'b1, 64'h0, 1'b1, "R10 idx 48F");
        run_read(12'h080, 64'h0, 1'b1, 64'h0, 1'b1, "R10 idx 080");
        run_read(12'hC81, 64'h0, 1'b1, 64'h0, 1'b1, "R10 idx C81");
        expect64("R10 result held after reads", {lpf, lqf}, {hp, hq});
        expect64("R10 valid stays low", {62'h0, lv, tv}, 64'h0);

        report();
    end

endmodule